// File: doc/BRIEF.md
# Fixed-Home Ownership Directory Slice

This block is the slice of a coherence directory held by one of `N_PROC` processors. Addresses are spread across the processors by interleaving, so each address has one fixed home: the processor whose ID equals the address modulo `N_PROC`. For every address homed here, the slice records which processor currently owns the block and which other processors hold read copies, kept as a bit per processor.

A requester presents a read or write query with its own processor ID and the address over a valid/ready handshake. One cycle later the slice answers with the owner the data must be fetched from. It also returns a hit flag when the requester already owns the block. For a write it returns the mask of processors that must drop their copies. A read adds the requester to the sharer set. A write hands ownership to the writer and empties the sharer set. Moving messages and data between processors is left to the surrounding fabric.

Top module: `dir_slice`

## Requirements
- R1: An address is homed here when its low `log2(N_PROC)` bits equal `HOME_ID`. Any other address gets a response with `rsp_nothome`=1, `rsp_hit`=0, `rsp_inval`=0 and `rsp_owner`=0, and changes no directory entry, including the entry that shares its upper address bits.
- R2: After reset every homed entry has owner `HOME_ID` and an empty sharer set. `req_ready` is low while reset is asserted and high from the first cycle after it.
- R3: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. Its response is presented with `rsp_valid` high during the next cycle only. While `rsp_valid` is low, all other response outputs are zero.
- R4: A read by a processor that is not the owner returns the current owner with `rsp_hit`=0 and `rsp_inval`=0. It adds the requester to the sharer set and leaves the owner unchanged.
- R5: A read by the current owner returns `rsp_hit`=1 and leaves the sharer set unchanged.
- R6: A write returns the previous owner in `rsp_owner`, makes the writer the new owner, and clears the sharer set.
- R7: For a write, `rsp_inval` is the union of the sharer set and the previous owner, with the writer removed. Bit i stands for processor i.
- R8: A write by the current owner returns `rsp_hit`=1, and its mask holds only the sharers other than the writer.
- R9: Requests are accepted back to back, one per cycle. A request sees every update made by the request accepted in the cycle before it.
- R10: Entries are independent. A request to one homed address never changes the owner or sharers of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slice can accept a request |
| req_write | input | 1 | 1 = write query, 0 = read query |
| req_src | input | log2(N_PROC) | ID of the requesting processor |
| req_addr | input | ADDR_W | Global block address |
| rsp_valid | output | 1 | Response present (one cycle per request) |
| rsp_owner | output | log2(N_PROC) | Owner before the request |
| rsp_hit | output | 1 | Requester was already the owner |
| rsp_nothome | output | 1 | Address is not homed at this slice |
| rsp_inval | output | N_PROC | Processors to invalidate (writes only) |

## Verification
The bound checker watches properties that hold on every cycle: a response follows each acceptance and appears at no other time, outputs stay quiet while idle, and `req_ready` stays high once raised. It also checks that the home decision matches the accepted address, that reads never invalidate, that a hit names the requester as owner, and that a writer never appears in its own mask. The bench's scenarios are the only place that shows the stored state is correct. This covers sharer accumulation, the hand-over of ownership, the exact mask contents, the isolation of entries, and that a request to a foreign address does not change the local entry that shares its upper bits. The bench shows these by comparing each response against a model of every address over long mixed request streams.

// File: rtl/dir_slice_pkg.sv
package dir_slice_pkg;
    typedef enum logic {
        DIR_OP_READ  = 1'b0,
        DIR_OP_WRITE = 1'b1
    } dir_op_e;
endpackage

// File: rtl/dir_home_decode.sv
// Splits a global address into "homed here" and the local entry index.
// N_PROC must be a power of two (>= 2) so the home is the low address bits.
module dir_home_decode #(
    parameter int N_PROC  = 4,
    parameter int HOME_ID = 1,
    parameter int ADDR_W  = 6,
    localparam int ID_W   = $clog2(N_PROC),
    localparam int IDX_W  = ADDR_W - ID_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_home,
    output logic [IDX_W-1:0]  idx
);
    assign is_home = (addr[ID_W-1:0] == ID_W'(HOME_ID));
    assign idx     = addr[ADDR_W-1:ID_W];
endmodule

// File: rtl/dir_entry_update.sv
// Next-state and response for one directory entry given a query.
module dir_entry_update
    import dir_slice_pkg::*;
#(
    parameter int N_PROC = 4,
    localparam int ID_W  = $clog2(N_PROC)
) (
    input  dir_op_e           op,
    input  logic [ID_W-1:0]   src,
    input  logic [ID_W-1:0]   own_in,
    input  logic [N_PROC-1:0] shr_in,
    output logic [ID_W-1:0]   own_out,
    output logic [N_PROC-1:0] shr_out,
    output logic              hit,
    output logic [N_PROC-1:0] inval
);
    logic [N_PROC-1:0] src_bit;
    logic [N_PROC-1:0] own_bit;

    for (genvar g = 0; g < N_PROC; g++) begin : g_bits
        assign src_bit[g] = (src    == ID_W'(g));
        assign own_bit[g] = (own_in == ID_W'(g));
    end

    always_comb begin
        hit = (src == own_in);
        if (op == DIR_OP_WRITE) begin
            own_out = src;
            shr_out = '0;
            inval   = (shr_in | own_bit) & ~src_bit;
        end else begin
            own_out = own_in;
            shr_out = hit ? shr_in : (shr_in | src_bit);
            inval   = '0;
        end
    end
endmodule

// File: rtl/dir_slice.sv
// Directory slice: owner + sharer vector per homed address, one query per cycle.
module dir_slice
    import dir_slice_pkg::*;
#(
    parameter int N_PROC  = 4,
    parameter int HOME_ID = 1,
    parameter int ADDR_W  = 6,
    localparam int ID_W   = $clog2(N_PROC),
    localparam int IDX_W  = ADDR_W - ID_W,
    localparam int DEPTH  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ID_W-1:0]   req_src,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_owner,
    output logic              rsp_hit,
    output logic              rsp_nothome,
    output logic [N_PROC-1:0] rsp_inval
);
    typedef struct packed {
        logic                              ready;
        logic                              rsp_v;
        logic [ID_W-1:0]                   rsp_own;
        logic                              rsp_hit;
        logic                              rsp_nh;
        logic [N_PROC-1:0]                 rsp_inv;
        logic [DEPTH-1:0][ID_W-1:0]        own;
        logic [DEPTH-1:0][N_PROC-1:0]      shr;
    } state_t;

    state_t state_d, state_q;

    logic              is_home;
    logic [IDX_W-1:0]  idx;
    logic [ID_W-1:0]   own_nx;
    logic [N_PROC-1:0] shr_nx;
    logic              hit_nx;
    logic [N_PROC-1:0] inv_nx;
    logic              accept;

    dir_home_decode #(
        .N_PROC (N_PROC),
        .HOME_ID(HOME_ID),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr   (req_addr),
        .is_home(is_home),
        .idx    (idx)
    );

    dir_entry_update #(
        .N_PROC(N_PROC)
    ) u_update (
        .op     (dir_op_e'(req_write)),
        .src    (req_src),
        .own_in (state_q.own[idx]),
        .shr_in (state_q.shr[idx]),
        .own_out(own_nx),
        .shr_out(shr_nx),
        .hit    (hit_nx),
        .inval  (inv_nx)
    );

    assign accept = req_valid && state_q.ready;

    always_comb begin
        state_d         = state_q;
        state_d.ready   = 1'b1;
        state_d.rsp_v   = 1'b0;
        state_d.rsp_own = '0;
        state_d.rsp_hit = 1'b0;
        state_d.rsp_nh  = 1'b0;
        state_d.rsp_inv = '0;
        if (accept) begin
            state_d.rsp_v = 1'b1;
            if (is_home) begin
                state_d.rsp_own  = state_q.own[idx];
                state_d.rsp_hit  = hit_nx;
                state_d.rsp_inv  = inv_nx;
                state_d.own[idx] = own_nx;
                state_d.shr[idx] = shr_nx;
            end else begin
                state_d.rsp_nh = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.ready   <= 1'b0;
            state_q.rsp_v   <= 1'b0;
            state_q.rsp_own <= '0;
            state_q.rsp_hit <= 1'b0;
            state_q.rsp_nh  <= 1'b0;
            state_q.rsp_inv <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                state_q.own[i] <= ID_W'(HOME_ID);
                state_q.shr[i] <= '0;
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign req_ready   = state_q.ready;
    assign rsp_valid   = state_q.rsp_v;
    assign rsp_owner   = state_q.rsp_own;
    assign rsp_hit     = state_q.rsp_hit;
    assign rsp_nothome = state_q.rsp_nh;
    assign rsp_inval   = state_q.rsp_inv;
endmodule

// File: rtl/dir_slice_chk.sv
module dir_slice_chk #(
    parameter int N_PROC  = 4,
    parameter int HOME_ID = 1,
    parameter int ADDR_W  = 6,
    localparam int ID_W   = $clog2(N_PROC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ID_W-1:0]   req_src,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [ID_W-1:0]   rsp_owner,
    input logic              rsp_hit,
    input logic              rsp_nothome,
    input logic [N_PROC-1:0] rsp_inval
);
    logic              last_wr;
    logic [ID_W-1:0]   last_src;
    logic [ADDR_W-1:0] last_addr;
    logic              fire;

    assign fire = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_wr   <= 1'b0;
            last_src  <= '0;
            last_addr <= '0;
        end else if (fire) begin
            last_wr   <= req_write;
            last_src  <= req_src;
            last_addr <= req_addr;
        end
    end

    p_rsp_follows_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid);
    p_no_rsp_without_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !rsp_valid);
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_inval == '0 && !rsp_hit && !rsp_nothome && rsp_owner == '0));
    p_ready_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);
    p_home_rule_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_nothome == ((last_addr % ADDR_W'(N_PROC)) != ADDR_W'(HOME_ID))));
    p_foreign_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_nothome) |-> (rsp_inval == '0 && !rsp_hit));
    p_read_no_inval_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !last_wr) |-> rsp_inval == '0);
    p_hit_means_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_owner == last_src);
    p_writer_not_invalidated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rsp_inval[last_src]);
endmodule

bind dir_slice dir_slice_chk #(
    .N_PROC (N_PROC),
    .HOME_ID(HOME_ID),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_src    (req_src),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_owner  (rsp_owner),
    .rsp_hit    (rsp_hit),
    .rsp_nothome(rsp_nothome),
    .rsp_inval  (rsp_inval)
);

// File: tb/tb_dir_slice.sv
`timescale 1ns/1ps
module tb_dir_slice;
    localparam int NP   = 4;
    localparam int HOME = 1;
    localparam int AW   = 6;
    localparam int NA   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [1:0]    req_src = '0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_owner;
    logic          rsp_hit;
    logic          rsp_nothome;
    logic [NP-1:0] rsp_inval;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    int       own_m [NA];
    bit [3:0] shr_m [NA];

    always #5 clk = ~clk;

    dir_slice #(.N_PROC(NP), .HOME_ID(HOME), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_src(req_src), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_owner(rsp_owner), .rsp_hit(rsp_hit),
        .rsp_nothome(rsp_nothome), .rsp_inval(rsp_inval)
    );

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] pack_rsp();
        return {rsp_valid, rsp_owner, rsp_hit, rsp_nothome, rsp_inval};
    endfunction

    // Drive one request at the current falling edge, check the response one edge later.
    task automatic issue(bit wr, int src, int addr, string tag);
        logic [8:0] exp;
        int         ow;
        bit         hit;
        bit [3:0]   inv;
        string      t;
        t = tag;
        if ((addr % NP) != HOME) begin
            exp = {1'b1, 2'b00, 1'b0, 1'b1, 4'h0};
            if (t == "") t = "R1";
        end else begin
            ow  = own_m[addr];
            hit = (src == ow);
            inv = 4'h0;
            if (wr) begin
                inv = (shr_m[addr] | 4'(1 << ow)) & ~4'(1 << src);
                own_m[addr] = src;
                shr_m[addr] = 4'h0;
                if (t == "") t = hit ? "R8" : "R7";
            end else begin
                if (!hit) shr_m[addr] = shr_m[addr] | 4'(1 << src);
                if (t == "") t = hit ? "R5" : "R4";
            end
            exp = {1'b1, 2'(ow), hit, 1'b0, inv};
        end
        req_valid = 1'b1;
        req_write = wr;
        req_src   = 2'(src);
        req_addr  = AW'(addr);
        @(negedge clk);
        check(t, pack_rsp(), exp);
    endtask

    task automatic idle(string tag);
        req_valid = 1'b0;
        @(negedge clk);
        check(tag, pack_rsp(), 9'h000);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < NA; a++) begin
            own_m[a] = HOME;
            shr_m[a] = 4'h0;
        end
        repeat (3) @(negedge clk);
        check("R2", {8'h00, req_ready}, 9'h000);      // ready low in reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", {7'h00, req_ready, rsp_valid}, 9'h002);

        // R2 / R1: owner reads every address; homed ones hit on HOME
        for (int a = 0; a < NA; a++)
            issue(1'b0, HOME, a, ((a % NP) == HOME) ? "R2" : "R1");
        idle("R3");

        // R4: non-owners read address 5 (homed, index 1)
        issue(1'b0, 0, 5, "R4");
        issue(1'b0, 3, 5, "R4");
        issue(1'b0, 0, 5, "R4");
        // R7: write by 3; mask = {0,3} + old owner 1 - writer 3 = 4'b0011
        issue(1'b1, 3, 5, "R7");
        // R6: new owner seen, sharers cleared
        issue(1'b0, 2, 5, "R6");
        issue(1'b0, 3, 5, "R6");
        // R8: owner writes; mask = sharer 2 only
        issue(1'b1, 3, 5, "R8");
        // R10: neighbouring homed entry untouched
        issue(1'b0, 0, 9, "R10");
        // R1: foreign address 4 shares index 1 with 5; entry 5 must not change
        issue(1'b1, 0, 4, "R1");
        issue(1'b0, 1, 5, "R1");
        // R9: back-to-back write then read by the new owner
        issue(1'b1, 2, 13, "R9");
        issue(1'b0, 2, 13, "R9");
        idle("R3");

        // Mixed stream over all addresses and sources
        for (int k = 0; k < 4000; k++) begin
            issue(1'($urandom % 2), int'($urandom % NP), int'($urandom % NA), "");
            if (($urandom % 8) == 0) idle("R3");
        end
        idle("R3");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule